// File: doc/BRIEF.md
# Read Enable Gate Training Sequencer

This controller finds, for each byte group of a memory read path, the moment at which the read-strobe enable gate should open. It trains one group at a time. For each group it holds a coarse latency count and steps a fine delay-tap code across its whole range. For every setting it sends a short run of read commands, with one idle cycle after each accepted command, so that the strobe shows a gap. It then checks the per-read gap verdicts that come back. The first setting at which every read reports the gap is kept as the group's result, and training moves on to the next group.

The memory, the delay lines and the gap detector sit outside the block. The block drives the group select, the tap code and the latency count. It issues commands through a request/acknowledge pair and takes one verdict per accepted command on a valid/hit pair. When every group is trained it pulses done. If a group runs past the highest latency without a match, the block raises a sticky fail flag and stops.

Top module: `rdgate_trainer`

## Requirements
- R1: Under reset, and on the first cycle after it, rd_req, done and fail are 0, and grp_sel, dly_code, lat_cnt and every result field are 0.
- R2: rd_req stays high until rd_ack is seen. After each accepted read, if more reads remain in the probe, rd_req is low for exactly one cycle and then high again.
- R3: Each probe issues exactly READS accepted reads. grp_sel, dly_code and lat_cnt do not change while a probe's reads are being issued.
- R4: A probe passes only if all READS verdicts have rd_resp_hit=1. A single miss fails the probe.
- R5: Within one group and latency, dly_code starts at 0 and rises by 1 after each failed probe.
- R6: A failed probe at the top tap code (all ones) raises lat_cnt by 1 and restarts dly_code at 0. lat_cnt never exceeds LAT_MAX.
- R7: The first read after start, or after any change of grp_sel, dly_code or lat_cnt, is raised exactly SETTLE cycles after the new setting appears on the outputs.
- R8: On a passing probe, the block stores dly_code in res_dly[g*DLY_W +: DLY_W] and lat_cnt in res_lat[g*LAT_W +: LAT_W] for group g. Groups are trained in ascending order, and each new group starts at dly_code=0 and lat_cnt=0.
- R9: done is high for exactly one cycle after the last group passes. No reads follow it, and the results hold.
- R10: A failed probe at the top tap code with lat_cnt=LAT_MAX sets fail, which then stays high with no further reads and no done. The next start clears fail.
- R11: start (acted on only when idle) clears every result field to 0, so groups left untrained by a failure read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin training all groups (idle only) |
| rd_req | output | 1 | Read command request |
| rd_ack | input | 1 | Read command accepted |
| rd_resp_vld | input | 1 | One verdict per accepted read |
| rd_resp_hit | input | 1 | Verdict: strobe gap seen for that read |
| grp_sel | output | GRP_W | Group under training |
| dly_code | output | DLY_W | Fine enable delay tap |
| lat_cnt | output | LAT_W | Coarse latency count |
| res_dly | output | NUM_GROUPS*DLY_W | Trained tap code per group |
| res_lat | output | NUM_GROUPS*LAT_W | Trained latency per group |
| done | output | 1 | One-cycle pulse when all groups pass |
| fail | output | 1 | Sticky: a group exhausted the search |

## Verification
The bench builds the block with 3 groups, a 3-bit tap code (8 taps), a latency ceiling of 5, 4 reads per probe and a 3-cycle settle. With these values a full search for one group is only 48 probes, so many complete training runs fit in one simulation. Those runs cover passing windows at every latency, the very last setting (latency 5, tap 7), a group that never matches, and a single missed verdict inside a window. A reference in the bench predicts every probe's setting and every result, and it runs with both immediate and irregular command acknowledges.

// File: rtl/rdgate_pkg.sv
package rdgate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_PROBE,
    ST_JUDGE
  } rg_state_e;
endpackage

// File: rtl/rdgate_settle.sv
module rdgate_settle #(
  parameter int SETTLE = 4,
  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= CW'(SETTLE - 1);
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/rdgate_burst.sv
module rdgate_burst #(
  parameter int READS = 8,
  localparam int RD_W = $clog2(READS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic ack,
  output logic req,
  output logic all_sent
);
  logic [RD_W-1:0] sent;
  logic            gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req   <= 1'b0;
      gap_q <= 1'b0;
      sent  <= '0;
    end else if (go) begin
      req   <= 1'b1;
      gap_q <= 1'b0;
      sent  <= '0;
    end else if (req && ack) begin
      req   <= 1'b0;
      sent  <= sent + RD_W'(1);
      gap_q <= (sent != RD_W'(READS - 1));
    end else if (gap_q) begin
      gap_q <= 1'b0;
      req   <= 1'b1;
    end
  end

  assign all_sent = (sent == RD_W'(READS));

  // R2: a request is held until accepted
  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    req && !ack |=> req);
  // R2: one idle cycle after an accepted read when more remain
  p_ack_gap_r2: assert property (@(posedge clk) disable iff (rst)
    req && ack && (sent != RD_W'(READS - 1)) |=> !req ##1 req);
endmodule

// File: rtl/rdgate_score.sv
module rdgate_score #(
  parameter int READS = 8,
  localparam int RD_W = $clog2(READS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic vld,
  input  logic hit,
  output logic seen_all,
  output logic all_hit
);
  logic [RD_W-1:0] cnt;
  logic            miss;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      miss <= 1'b0;
    end else if (vld && (cnt != RD_W'(READS))) begin
      cnt <= cnt + RD_W'(1);
      if (!hit) miss <= 1'b1;
    end
  end

  assign seen_all = (cnt == RD_W'(READS));
  assign all_hit  = !miss;

  // R3: no more verdicts than reads in one probe
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    vld |-> (cnt != RD_W'(READS)));
endmodule

// File: rtl/rdgate_trainer.sv
module rdgate_trainer
  import rdgate_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int DLY_W      = 5,
  parameter int LAT_W      = 4,
  parameter int LAT_MAX    = 15,
  parameter int READS      = 8,
  parameter int SETTLE     = 4,
  localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  output logic                        rd_req,
  input  logic                        rd_ack,
  input  logic                        rd_resp_vld,
  input  logic                        rd_resp_hit,
  output logic [GRP_W-1:0]            grp_sel,
  output logic [DLY_W-1:0]            dly_code,
  output logic [LAT_W-1:0]            lat_cnt,
  output logic [NUM_GROUPS*DLY_W-1:0] res_dly,
  output logic [NUM_GROUPS*LAT_W-1:0] res_lat,
  output logic                        done,
  output logic                        fail
);
  localparam logic [DLY_W-1:0] DLY_TOP = {DLY_W{1'b1}};
  localparam logic [LAT_W-1:0] LAT_TOP = LAT_W'(LAT_MAX);
  localparam logic [GRP_W-1:0] GRP_TOP = GRP_W'(NUM_GROUPS - 1);

  rg_state_e        state;
  logic [GRP_W-1:0] grp_q;
  logic [DLY_W-1:0] dly_q;
  logic [LAT_W-1:0] lat_q;
  logic             done_q, fail_q;
  logic [DLY_W-1:0] r_dly [NUM_GROUPS];
  logic [LAT_W-1:0] r_lat [NUM_GROUPS];

  logic tmr_load, tmr_expired, go, all_sent, seen_all, all_hit;
  logic last_grp, dly_top, lat_top;

  assign last_grp = (grp_q == GRP_TOP);
  assign dly_top  = (dly_q == DLY_TOP);
  assign lat_top  = (lat_q == LAT_TOP);
  assign go       = (state == ST_SETTLE) && tmr_expired;
  assign tmr_load = ((state == ST_IDLE) && start) ||
                    ((state == ST_JUDGE) &&
                     (all_hit ? !last_grp : !(dly_top && lat_top)));

  rdgate_settle #(.SETTLE(SETTLE)) u_settle (
    .clk(clk), .rst(rst), .load(tmr_load), .expired(tmr_expired)
  );

  rdgate_burst #(.READS(READS)) u_burst (
    .clk(clk), .rst(rst), .go(go), .ack(rd_ack),
    .req(rd_req), .all_sent(all_sent)
  );

  rdgate_score #(.READS(READS)) u_score (
    .clk(clk), .rst(rst), .clr(go), .vld(rd_resp_vld), .hit(rd_resp_hit),
    .seen_all(seen_all), .all_hit(all_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      grp_q  <= '0;
      dly_q  <= '0;
      lat_q  <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      for (int i = 0; i < NUM_GROUPS; i++) begin
        r_dly[i] <= '0;
        r_lat[i] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_SETTLE;
          grp_q  <= '0;
          dly_q  <= '0;
          lat_q  <= '0;
          fail_q <= 1'b0;
          for (int i = 0; i < NUM_GROUPS; i++) begin
            r_dly[i] <= '0;
            r_lat[i] <= '0;
          end
        end
        ST_SETTLE: if (tmr_expired) state <= ST_PROBE;
        ST_PROBE:  if (seen_all && all_sent) state <= ST_JUDGE;
        ST_JUDGE: begin
          if (all_hit) begin
            r_dly[grp_q] <= dly_q;
            r_lat[grp_q] <= lat_q;
            if (last_grp) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              grp_q <= grp_q + GRP_W'(1);
              dly_q <= '0;
              lat_q <= '0;
              state <= ST_SETTLE;
            end
          end else if (!dly_top) begin
            dly_q <= dly_q + DLY_W'(1);
            state <= ST_SETTLE;
          end else if (!lat_top) begin
            lat_q <= lat_q + LAT_W'(1);
            dly_q <= '0;
            state <= ST_SETTLE;
          end else begin
            fail_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_pack
    assign res_dly[g*DLY_W +: DLY_W] = r_dly[g];
    assign res_lat[g*LAT_W +: LAT_W] = r_lat[g];
  end

  assign grp_sel  = grp_q;
  assign dly_code = dly_q;
  assign lat_cnt  = lat_q;
  assign done     = done_q;
  assign fail     = fail_q;

  // R3: the setting holds whenever a read is requested
  p_setting_stable_r3: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> ($stable(dly_code) && $stable(lat_cnt) && $stable(grp_sel)));
  // R6: coarse latency stays within its ceiling
  p_lat_bound_r6: assert property (@(posedge clk) disable iff (rst)
    lat_cnt <= LAT_TOP);
  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10: a failed run is silent
  p_fail_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    fail |-> (!rd_req && !done));
endmodule

// File: tb/test_rdgate_trainer.sv
module test_rdgate_trainer;
  localparam int NG = 3, DW = 3, LW = 3, LMAX = 5, NRD = 4, STL = 3, GW = 2;
  localparam int DMAX = (1 << DW) - 1;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic rd_ack = 1'b0, rd_resp_vld = 1'b0, rd_resp_hit = 1'b0;
  logic rd_req, done, fail;
  logic [GW-1:0] grp_sel;
  logic [DW-1:0] dly_code;
  logic [LW-1:0] lat_cnt;
  logic [NG*DW-1:0] res_dly;
  logic [NG*LW-1:0] res_lat;

  always #5 clk = ~clk;

  rdgate_trainer #(.NUM_GROUPS(NG), .DLY_W(DW), .LAT_W(LW), .LAT_MAX(LMAX),
                   .READS(NRD), .SETTLE(STL)) i_rdgate_trainer (
    .clk(clk), .rst(rst), .start(start), .rd_req(rd_req), .rd_ack(rd_ack),
    .rd_resp_vld(rd_resp_vld), .rd_resp_hit(rd_resp_hit), .grp_sel(grp_sel),
    .dly_code(dly_code), .lat_cnt(lat_cnt), .res_dly(res_dly), .res_lat(res_lat),
    .done(done), .fail(fail)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  int tl[NG], tlo[NG], thi[NG];
  int fl_grp = -1, fl_code = 0, ack_mode = 0;
  int exp_grp, exp_lat, exp_dly, exp_end;
  int er_dly[NG], er_lat[NG];
  int done_cnt = 0, probes = 0, hs_total = 0;
  int prev_set = 0, scnt = 0, rd_idx = 0, gap_stage = 0;
  bit prev_start = 0, first_pend = 0;
  bit pv[3], ph[3];
  logic [15:0] lfsr = 16'hACE1;

  function automatic bit in_win(input int g, input int l, input int d);
    return (l == tl[g]) && (d >= tlo[g]) && (d <= thi[g]);
  endfunction

  // memory-side model and probe-by-probe reference
  always @(negedge clk) begin
    int  set_now;
    bit  newack, hs, hit, pass;
    if (rst) begin
      rd_ack = 0; rd_resp_vld = 0; rd_resp_hit = 0;
      rd_idx = 0; gap_stage = 0; first_pend = 0; scnt = 0;
      for (int i = 0; i < 3; i++) begin pv[i] = 0; ph[i] = 0; end
      prev_set = 0; prev_start = 0;
    end else begin
      set_now = int'(grp_sel) * 100 + int'(lat_cnt) * 10 + int'(dly_code);
      if (set_now != prev_set) begin
        chk(rd_idx == 0, "R3 setting changed mid-probe", rd_idx, 0);
        scnt = 0; first_pend = 1;
      end else if (prev_start) begin
        scnt = 0; first_pend = 1;
      end else scnt++;
      prev_set = set_now;
      prev_start = start;
      if (done) done_cnt++;

      if (gap_stage == 1) begin
        chk(rd_req == 1'b0, "R2 idle cycle after ack", int'(rd_req), 0);
        gap_stage = 2;
      end else if (gap_stage == 2) begin
        chk(rd_req == 1'b1, "R2 request after idle cycle", int'(rd_req), 1);
        gap_stage = 0;
      end

      if (rd_req && first_pend) begin
        first_pend = 0;
        probes++;
        chk(scnt == STL, "R7 settle length", scnt, STL);
        if (exp_end != 0) chk(1'b0, "R10 read after finish", set_now, -1);
        else begin
          chk(int'(grp_sel) == exp_grp, "R8 group order", int'(grp_sel), exp_grp);
          chk(int'(lat_cnt) == exp_lat, "R6 latency step", int'(lat_cnt), exp_lat);
          chk(int'(dly_code) == exp_dly, "R5 tap step", int'(dly_code), exp_dly);
          pass = in_win(exp_grp, exp_lat, exp_dly) &&
                 !(exp_grp == fl_grp && exp_dly == fl_code);
          if (pass) begin
            er_dly[exp_grp] = exp_dly; er_lat[exp_grp] = exp_lat;
            if (exp_grp == NG - 1) exp_end = 1;
            else begin exp_grp++; exp_lat = 0; exp_dly = 0; end
          end else if (exp_dly < DMAX) exp_dly++;
          else if (exp_lat < LMAX) begin exp_lat++; exp_dly = 0; end
          else exp_end = 2;
        end
      end

      rd_resp_vld = pv[0]; rd_resp_hit = ph[0];
      pv[0] = pv[1]; ph[0] = ph[1]; pv[1] = pv[2]; ph[1] = ph[2];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      newack = (ack_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
      rd_ack = newack;
      hs = rd_req && newack;
      hit = in_win(int'(grp_sel), int'(lat_cnt), int'(dly_code)) &&
            !(int'(grp_sel) == fl_grp && int'(dly_code) == fl_code && rd_idx == 2);
      pv[2] = hs; ph[2] = hs && hit;
      if (hs) begin
        hs_total++;
        rd_idx++;
        if (rd_idx == NRD) begin rd_idx = 0; gap_stage = 0; end
        else gap_stage = 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(1'b0, "watchdog expired", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic train();
    int snap;
    @(posedge clk); #1;
    exp_grp = 0; exp_lat = 0; exp_dly = 0; exp_end = 0;
    for (int g = 0; g < NG; g++) begin er_dly[g] = 0; er_lat[g] = 0; end
    done_cnt = 0; probes = 0; hs_total = 0;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(fail == 1'b0, "R10 start clears fail", int'(fail), 0);
    for (int i = 0; i < 20000 && !(done || fail); i++) begin
      @(posedge clk); #1;
    end
    repeat (5) @(posedge clk);
    snap = hs_total;
    repeat (20) @(posedge clk);
    #1;
    chk(hs_total == snap, "R9 no reads after finish", hs_total, snap);
    chk(exp_end != 0, "R10 reference expected finish", exp_end, 1);
    chk(done_cnt == ((exp_end == 1) ? 1 : 0), "R9 done pulse count", done_cnt,
        (exp_end == 1) ? 1 : 0);
    chk(fail == (exp_end == 2), "R10 fail flag", int'(fail), (exp_end == 2) ? 1 : 0);
    chk(hs_total == probes * NRD, "R3 reads per probe", hs_total, probes * NRD);
    for (int g = 0; g < NG; g++) begin
      chk(int'(res_dly[g*DW +: DW]) == er_dly[g], "R8 R11 stored tap",
          int'(res_dly[g*DW +: DW]), er_dly[g]);
      chk(int'(res_lat[g*LW +: LW]) == er_lat[g], "R8 R11 stored latency",
          int'(res_lat[g*LW +: LW]), er_lat[g]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(rd_req == 0 && done == 0 && fail == 0, "R1 control outputs", int'(rd_req) + int'(done) + int'(fail), 0);
    chk(grp_sel == 0 && dly_code == 0 && lat_cnt == 0, "R1 setting", int'(dly_code), 0);
    chk(res_dly == 0 && res_lat == 0, "R1 results", int'(res_dly), 0);

    // sweep of windows across latencies, taps and widths
    for (int r = 0; r < 18; r++) begin
      ack_mode = r % 2;
      for (int g = 0; g < NG; g++) begin
        tl[g]  = (r + 2 * g) % (LMAX + 1);
        tlo[g] = (3 * r + 5 * g) % (DMAX + 1);
        thi[g] = (tlo[g] + r % 3 > DMAX) ? DMAX : tlo[g] + r % 3;
      end
      train();
    end

    // last setting of the search is the only match
    ack_mode = 1;
    for (int g = 0; g < NG; g++) begin tl[g] = LMAX; tlo[g] = DMAX; thi[g] = DMAX; end
    train();

    // R4: one missed verdict at the window edge rejects that tap
    ack_mode = 0;
    for (int g = 0; g < NG; g++) begin tl[g] = g; tlo[g] = 1; thi[g] = 4; end
    tl[0] = 1; tlo[0] = 2; thi[0] = 5; fl_grp = 0; fl_code = 2;
    train();
    chk(int'(res_dly[DW-1:0]) == 3, "R4 probe with one miss rejected", int'(res_dly[DW-1:0]), 3);
    fl_grp = -1;

    // R10 R11: group 1 never matches
    tl[1] = 7;
    train();
    chk(fail == 1'b1, "R10 unreachable group fails", int'(fail), 1);

    // recovery after a failure
    tl[1] = 2; ack_mode = 1;
    train();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule